// File: doc/BRIEF.md
# Programmable Clock Channel Divider

One output channel of a clock distribution block. The source clock is divided by a programmable ratio, with the high time and the low time of the output set independently. Each is a 4-bit field holding the length in source cycles minus one, so any pair of phase lengths from 1 to 16 cycles can be built, including uneven duty cycles.

An asynchronous SYNC request aligns several channels. It is first passed through a two-stage synchroniser. While it is held, the channel parks its output at a selectable start level. On release, the channel waits a programmable number of source cycles and then begins counting. A channel can ignore SYNC. In that mode it can also hold a static high output. A bypass path routes the source clock straight to the output. A power-down control deasserts the output enable, which models a driver in the high-impedance state.

The control fields arrive as plain input ports from an external register set. A change to the count fields is picked up only at a phase boundary, so no output pulse is ever cut short.

Top module: `clk_chan_div`

## Requirements
- R1: A high-time field value N keeps `clk_o` high for exactly N+1 source cycles in steady-state division.
- R2: A low-time field value N keeps `clk_o` low for exactly N+1 source cycles in steady-state division.
- R3: While `rst_ni` is low, `clk_o` is 0 and `oe_o` is 1, provided power-down is clear.
- R4: With `bypass_i` = 1 and power-down clear, `clk_o` follows `clk_i`, and the counter stays idle in the parked state.
- R5: While the synchronised SYNC is asserted and obeyed, `clk_o` holds the start level. The first output transition comes on the 3+P+L-th rising edge after `sync_req_i` falls. Here P is the offset field and L is the length of the start phase. The two edges before that are synchroniser latency.
- R6: `start_hi_i` = 1 selects a high first phase after SYNC release, and 0 selects a low first phase.
- R7: The 4-bit offset field P delays the first output transition after SYNC release by P source cycles. A value of 0 adds no delay.
- R8: With `ign_sync_i` = 1, asserting `sync_req_i` does not stop or realign the running divider.
- R9: With `ign_sync_i` = 1 and `force_hi_i` = 1, `clk_o` stays high. With `ign_sync_i` = 0, `force_hi_i` has no effect.
- R10: With `pwr_dn_i` = 1, `oe_o` is 0 and `clk_o` is 0. With `pwr_dn_i` = 0, `oe_o` is 1.
- R11: A change to the high or low field takes effect at the next phase boundary. The phase already running keeps the length it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_req_i | input | 1 | Asynchronous SYNC request, active high |
| hi_cnt_i | input | CW | High time minus one, in source cycles |
| lo_cnt_i | input | CW | Low time minus one, in source cycles |
| phase_i | input | PW | Offset in source cycles, applied after SYNC release |
| start_hi_i | input | 1 | Level of the first phase after SYNC release |
| bypass_i | input | 1 | Route the source clock to the output |
| ign_sync_i | input | 1 | Ignore SYNC |
| force_hi_i | input | 1 | Hold a static high output (needs `ign_sync_i`) |
| pwr_dn_i | input | 1 | Channel power-down |
| clk_o | output | 1 | Divided clock |
| oe_o | output | 1 | Output enable; low models high impedance |

## Verification
The divide function is driven by a table of high, low, offset and start-level settings. Each entry is released from SYNC, and the bench counts the cycles to the first edge and the lengths of the next two phases. The settings include symmetric ratios, the extremes 0 and 15 in both fields, uneven duty cycles, and offsets of 0, 7 and 15. Together these separate a high/low field swap, an off-by-one in the minus-one encoding, and a wrong offset or synchroniser depth, because each of these faults moves a different one of the three counts. Directed cases then change the fields partway through a phase, and toggle SYNC while it is ignored. They also cover force, bypass and power-down, each checked against the opposite setting.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;
  typedef enum logic [1:0] {
    ST_PARK = 2'd0,
    ST_OFFS = 2'd1,
    ST_RUN  = 2'd2
  } div_st_e;
endpackage

// File: rtl/clk_div_sync.sv
module clk_div_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_div_core.sv
module clk_div_core
  import clk_div_pkg::*;
#(
  parameter int CW     = 4,
  parameter int PW     = 4,
  parameter int HI_RST = 3,
  parameter int LO_RST = 3,
  localparam int NW    = (CW > PW) ? CW : PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic          idle_i,
  input  logic          start_hi_i,
  input  logic [CW-1:0] hi_i,
  input  logic [CW-1:0] lo_i,
  input  logic [PW-1:0] phase_i,
  output logic          lvl_o,
  output div_st_e       st_o,
  output logic [NW-1:0] cnt_o
);
  div_st_e       st_q;
  logic [NW-1:0] cnt_q;
  logic          lvl_q;
  logic [CW-1:0] hi_q, lo_q;
  logic [PW-1:0] ph_q;
  logic [NW-1:0] lim;
  logic [NW-1:0] ph_last;

  // phase limit comes from latched fields only
  assign lim     = lvl_q ? NW'(hi_q) : NW'(lo_q);
  assign ph_last = NW'(ph_q) - NW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_PARK;
      cnt_q <= '0;
      lvl_q <= 1'b0;
      hi_q  <= CW'(HI_RST);
      lo_q  <= CW'(LO_RST);
      ph_q  <= '0;
    end else if (hold_i || idle_i) begin
      st_q  <= ST_PARK;
      cnt_q <= '0;
      lvl_q <= start_hi_i;
      hi_q  <= hi_i;
      lo_q  <= lo_i;
      ph_q  <= phase_i;
    end else begin
      unique case (st_q)
        ST_PARK: begin
          cnt_q <= '0;
          lvl_q <= start_hi_i;
          hi_q  <= hi_i;
          lo_q  <= lo_i;
          ph_q  <= phase_i;
          st_q  <= (phase_i == '0) ? ST_RUN : ST_OFFS;
        end
        ST_OFFS: begin
          if (cnt_q == ph_last) begin
            cnt_q <= '0;
            st_q  <= ST_RUN;
          end else begin
            cnt_q <= cnt_q + NW'(1);
          end
        end
        ST_RUN: begin
          if (cnt_q == lim) begin
            cnt_q <= '0;
            lvl_q <= ~lvl_q;
            hi_q  <= hi_i;   // new ratio only at a boundary
            lo_q  <= lo_i;
          end else begin
            cnt_q <= cnt_q + NW'(1);
          end
        end
        default: begin
          st_q  <= ST_PARK;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign lvl_o = lvl_q;
  assign st_o  = st_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/clk_div_out.sv
module clk_div_out (
  input  logic clk_i,
  input  logic lvl_i,
  input  logic bypass_i,
  input  logic ign_sync_i,
  input  logic force_hi_i,
  input  logic pwr_dn_i,
  output logic clk_o,
  output logic oe_o
);
  logic pre;

  always_comb begin
    if (bypass_i)                     pre = clk_i;
    else if (ign_sync_i && force_hi_i) pre = 1'b1;
    else                              pre = lvl_i;
  end

  assign clk_o = pre & ~pwr_dn_i;
  assign oe_o  = ~pwr_dn_i;
endmodule

// File: rtl/clk_chan_div.sv
module clk_chan_div
  import clk_div_pkg::*;
#(
  parameter int CW          = 4,
  parameter int PW          = 4,
  parameter int HI_RST      = 3,
  parameter int LO_RST      = 3,
  parameter int SYNC_STAGES = 2,
  localparam int NW         = (CW > PW) ? CW : PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_req_i,
  input  logic [CW-1:0] hi_cnt_i,
  input  logic [CW-1:0] lo_cnt_i,
  input  logic [PW-1:0] phase_i,
  input  logic          start_hi_i,
  input  logic          bypass_i,
  input  logic          ign_sync_i,
  input  logic          force_hi_i,
  input  logic          pwr_dn_i,
  output logic          clk_o,
  output logic          oe_o
);
  logic          sync_s;
  logic          hold;
  logic          lvl;
  div_st_e       st;
  logic [NW-1:0] cnt;

  clk_div_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sync_req_i),
    .q_o   (sync_s)
  );

  assign hold = sync_s & ~ign_sync_i;

  clk_div_core #(
    .CW(CW), .PW(PW), .HI_RST(HI_RST), .LO_RST(LO_RST)
  ) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .idle_i    (bypass_i),
    .start_hi_i(start_hi_i),
    .hi_i      (hi_cnt_i),
    .lo_i      (lo_cnt_i),
    .phase_i   (phase_i),
    .lvl_o     (lvl),
    .st_o      (st),
    .cnt_o     (cnt)
  );

  clk_div_out u_out (
    .clk_i     (clk_i),
    .lvl_i     (lvl),
    .bypass_i  (bypass_i),
    .ign_sync_i(ign_sync_i),
    .force_hi_i(force_hi_i),
    .pwr_dn_i  (pwr_dn_i),
    .clk_o     (clk_o),
    .oe_o      (oe_o)
  );
endmodule

// File: rtl/clk_chan_div_chk.sv
module clk_chan_div_chk
  import clk_div_pkg::*;
#(
  parameter int NW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sync_s_i,
  input logic          ign_sync_i,
  input logic          start_hi_i,
  input logic          bypass_i,
  input logic          pwr_dn_i,
  input logic          lvl_i,
  input div_st_e       st_i,
  input logic [NW-1:0] cnt_i,
  input logic          clk_o,
  input logic          oe_o
);
  logic       lvl_d;
  logic [5:0] run_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_d   <= 1'b0;
      run_len <= '0;
    end else begin
      lvl_d <= lvl_i;
      if (st_i != ST_RUN || lvl_i != lvl_d) run_len <= '0;
      else if (run_len != 6'h3f)            run_len <= run_len + 6'd1;
    end
  end

  p_hold_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_s_i && !ign_sync_i) |=> (lvl_i == $past(start_hi_i)));

  p_phase_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN) |-> (run_len <= 6'd16));

  p_bypass_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (st_i == ST_PARK && cnt_i == '0));

  p_ignore_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_RUN && ign_sync_i && !bypass_i) |=> (st_i == ST_RUN));

  p_offset_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_OFFS) |-> (cnt_i < NW'(15)));

  p_power_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_dn_i |-> (!oe_o && !clk_o));
endmodule

bind clk_chan_div clk_chan_div_chk #(.NW(NW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_s_i  (sync_s),
  .ign_sync_i(ign_sync_i),
  .start_hi_i(start_hi_i),
  .bypass_i  (bypass_i),
  .pwr_dn_i  (pwr_dn_i),
  .lvl_i     (lvl),
  .st_i      (st),
  .cnt_i     (cnt),
  .clk_o     (clk_o),
  .oe_o      (oe_o)
);

// File: tb/clk_chan_div_test.sv
`timescale 1ns/1ps
module clk_chan_div_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_req = 1'b0;
  logic [3:0] hi = 4'd3, lo = 4'd3, ph = 4'd0;
  logic       start_hi = 1'b0, byp = 1'b0, ign = 1'b0, frc = 1'b0, pd = 1'b0;
  logic       clk_o, oe_o;
  int         checks = 0, errors = 0;
  int         cyc = 0;

  always #4 clk = ~clk;

  clk_chan_div uut (
    .clk_i(clk), .rst_ni(rst_n), .sync_req_i(sync_req),
    .hi_cnt_i(hi), .lo_cnt_i(lo), .phase_i(ph), .start_hi_i(start_hi),
    .bypass_i(byp), .ign_sync_i(ign), .force_hi_i(frc), .pwr_dn_i(pd),
    .clk_o(clk_o), .oe_o(oe_o)
  );

  // {hi, lo, offset, start}
  localparam logic [15:0] VEC [6] = '{
    16'h3300, 16'h1100, 16'h0000, 16'hF201, 16'h2570, 16'h0FF1
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_len(output int n);
    logic lv;
    lv = clk_o;
    n = 1;
    for (int k = 0; k < 40; k++) begin
      step();
      if (clk_o != lv) break;
      n++;
    end
  endtask

  task automatic release_and_first(input logic s, output int n);
    sync_req = 1'b1;
    for (int k = 0; k < 5; k++) step();
    sync_req = 1'b0;
    n = 0;
    for (int k = 0; k < 60; k++) begin
      step();
      n++;
      if (clk_o != s) break;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n, r1, r2, r3;
    int e_hi, e_lo, e_first;
    logic s;
    @(negedge clk);
    chk(clk_o == 1'b0, "R3 clk_o in reset", clk_o, 0);
    chk(oe_o == 1'b1, "R3 oe_o in reset", oe_o, 1);
    step();
    rst_n = 1'b1;
    step();

    for (int i = 0; i < 6; i++) begin
      hi = VEC[i][15:12]; lo = VEC[i][11:8]; ph = VEC[i][7:4]; s = VEC[i][0];
      start_hi = s;
      e_hi = int'(hi) + 1;
      e_lo = int'(lo) + 1;
      e_first = 3 + int'(ph) + (s ? e_hi : e_lo);
      sync_req = 1'b1;
      for (int k = 0; k < 5; k++) step();
      chk(clk_o == s, "R6 parked at start level", clk_o, s);
      release_and_first(s, n);
      chk(n == e_first, "R5/R7 first edge after release", n, e_first);
      run_len(r1);
      run_len(r2);
      chk(r1 == (s ? e_lo : e_hi), s ? "R2 low run" : "R1 high run", r1, s ? e_lo : e_hi);
      chk(r2 == (s ? e_hi : e_lo), s ? "R1 high run" : "R2 low run", r2, s ? e_hi : e_lo);
    end

    // R11: fields changed just after a phase starts
    hi = 4'd3; lo = 4'd3; ph = 4'd0; start_hi = 1'b0;
    release_and_first(1'b0, n);
    hi = 4'd0; lo = 4'd1;
    run_len(r1);
    run_len(r2);
    run_len(r3);
    chk(r1 == 4, "R11 running high phase kept", r1, 4);
    chk(r2 == 2, "R11 new low time", r2, 2);
    chk(r3 == 1, "R11 new high time", r3, 1);

    // R8: SYNC ignored while running
    hi = 4'd1; lo = 4'd1;
    release_and_first(1'b0, n);
    ign = 1'b1;
    sync_req = 1'b1;
    for (int k = 0; k < 5; k++) step();
    n = 0;
    for (int k = 0; k < 12; k++) begin
      logic p;
      p = clk_o;
      step();
      if (clk_o != p) n++;
    end
    chk(n == 6, "R8 toggles with SYNC ignored", n, 6);

    // R9: force high
    frc = 1'b1;
    n = 0;
    for (int k = 0; k < 8; k++) begin
      step();
      if (clk_o) n++;
    end
    chk(n == 8, "R9 forced high", n, 8);
    sync_req = 1'b0;
    ign = 1'b0;
    for (int k = 0; k < 3; k++) step();
    n = 0;
    for (int k = 0; k < 12; k++) begin
      logic p;
      p = clk_o;
      step();
      if (clk_o != p) n++;
    end
    chk(n == 6, "R9 force ignored without ignore-SYNC", n, 6);
    frc = 1'b0;

    // R4: bypass
    byp = 1'b1;
    step();
    chk(clk_o == 1'b0, "R4 bypass low half", clk_o, 0);
    @(posedge clk); #1;
    chk(clk_o == 1'b1, "R4 bypass high half", clk_o, 1);
    @(negedge clk);
    byp = 1'b0;

    // R10: power-down
    pd = 1'b1;
    step();
    chk(oe_o == 1'b0, "R10 oe_o low", oe_o, 0);
    n = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      if (clk_o) n++;
    end
    chk(n == 0, "R10 clk_o quiet", n, 0);
    pd = 1'b0;
    step();
    chk(oe_o == 1'b1, "R10 oe_o restored", oe_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule